// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block sends bytes on an asynchronous serial line. A single holding register sits in front of the shift register. A new byte can be loaded while the previous frame is still on the wire, so frames go out back to back with no idle gap. Each frame has four parts:

- a low start bit;
- eight data bits, least significant first;
- an optional ninth bit;
- a high stop bit.

The ninth-bit mode and the ninth-bit value are captured together with the byte at the moment it is written. Changing those inputs later has no effect on a frame that is already queued or on the wire.

Bit timing comes from a down-counter that reloads from the divisor input, so every bit lasts divisor+1 clocks. The counter is restarted only when a frame begins from idle. Writing the holding register, changing the mode inputs, or reaching the end of a stop bit never restarts it.

When the next frame is already waiting at the start of a stop bit, its byte moves into the shift register at that moment. The holding register therefore reports empty as soon as the stop bit begins. A write to a holding register that is still full is dropped, and a one-clock collision pulse signals the drop.

Top module: `uart_dbtx`

## Requirements
- R1: After synchronous reset, and whenever no frame is in progress, the line is high. After reset, hold_empty and shift_empty are 1 and collide_o is 0.
- R2: A frame is one low start bit, then wr_data bits 0 to 7 in that order, then one high stop bit. Every bit lasts baud_div+1 clock cycles.
- R3: If bit9_en was 1 when the byte was written, the value bit9_val had at that write is sent as one extra bit. It follows data bit 7 and comes before the stop bit.
- R4: A write accepted while the block is idle drives hold_empty low on the next clock. On the clock after that, the start bit begins, hold_empty returns high and shift_empty goes low.
- R5: A frame queued before the current stop bit ends starts on the clock where that stop bit ends, with no idle cycle between the two frames.
- R6: If a byte is waiting when the stop bit begins, hold_empty rises on that same clock. Without a write, an empty holding register stays empty.
- R7: shift_empty is low from the first start-bit cycle until the last stop bit ends, including across back-to-back frames.
- R8: A write while hold_empty is 0 is ignored, so no frame carries its data. collide_o is then high for exactly the one following clock.
- R9: Changing bit9_en or bit9_val while frames are queued or in flight does not alter their content or bit timing.
- R10: A write accepted on the clock where a stop bit ends (idle otherwise) produces exactly one frame with that data. No extra frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Bit period minus one, in clocks |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| bit9_en | input | 1 | Send a ninth bit with this byte |
| bit9_val | input | 1 | Ninth bit value for this byte |
| hold_empty | output | 1 | Holding register can accept a write |
| shift_empty | output | 1 | No frame in progress |
| collide_o | output | 1 | One-clock pulse after an ignored write |
| tx_o | output | 1 | Serial line, idles high |

## Verification
The critical coincidence is a holding-register write landing on the same clock as the baud tick that ends a stop bit. At that instant the sequencer decides between idle and a new start bit while the holding register is filling.

The bench times a second write relative to a frame it launched from idle. It sweeps the write over two clocks before the boundary, the boundary itself, and one clock after, with the block idle between runs.

A scoreboard pairs every decoded frame with a queued expectation. Any extra or missing frame, or any wrong bit, is reported.

// File: rtl/udt_pkg.sv
package udt_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } fr_state_t;

    typedef struct packed {
        logic              nine_en;
        logic              nine;
        logic [DATA_W-1:0] data;
    } tx_word_t;

    function automatic logic line_level(fr_state_t s, logic d0, logic n);
        case (s)
            ST_START: line_level = 1'b0;
            ST_DATA:  line_level = d0;
            ST_NINTH: line_level = n;
            default:  line_level = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/udt_baud.sv
module udt_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= div;
        end else if (run) begin
            if (cnt == '0) cnt <= div;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && !restart && (cnt == '0);

endmodule

// File: rtl/udt_hold.sv
module udt_hold
    import udt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_stb,
    input  tx_word_t wr_word,
    input  logic     take,
    output logic     full,
    output tx_word_t word,
    output logic     collide
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= 1'b0;
            word    <= '0;
            collide <= 1'b0;
        end else begin
            collide <= wr_stb && full;
            if (wr_stb && !full) begin
                full <= 1'b1;
                word <= wr_word;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/udt_framer.sv
module udt_framer
    import udt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     hold_full,
    input  tx_word_t hold_word,
    output logic     take,
    output logic     restart,
    output logic     run,
    output logic     idle,
    output logic     tx
);

    fr_state_t         st;
    logic [DATA_W-1:0] sh;
    logic              nine;
    logic              nine_en;
    logic              pend;
    logic [IDX_W-1:0]  idx;

    logic last_data;
    logic enter_stop;
    logic stop_end;

    always_comb begin
        last_data  = (st == ST_DATA) && (idx == IDX_W'(DATA_W - 1));
        enter_stop = tick && ((last_data && !nine_en) || (st == ST_NINTH));
        stop_end   = tick && (st == ST_STOP);
        take       = hold_full && ((st == ST_IDLE) || enter_stop || (stop_end && !pend));
        restart    = hold_full && (st == ST_IDLE);
        run        = (st != ST_IDLE);
        idle       = (st == ST_IDLE);
        tx         = line_level(st, sh[0], nine);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sh      <= '0;
            nine    <= 1'b0;
            nine_en <= 1'b0;
            pend    <= 1'b0;
            idx     <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (hold_full) st <= ST_START;
                end
                ST_START: begin
                    if (tick) begin
                        st  <= ST_DATA;
                        idx <= '0;
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        sh <= sh >> 1;
                        if (last_data) st <= nine_en ? ST_NINTH : ST_STOP;
                        else           idx <= idx + 1'b1;
                    end
                end
                ST_NINTH: begin
                    if (tick) st <= ST_STOP;
                end
                ST_STOP: begin
                    if (tick) st <= (pend || hold_full) ? ST_START : ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase

            if (enter_stop)    pend <= hold_full;
            else if (stop_end) pend <= 1'b0;

            if (take) begin
                sh      <= hold_word.data;
                nine    <= hold_word.nine;
                nine_en <= hold_word.nine_en;
            end
        end
    end

endmodule

// File: rtl/uart_dbtx.sv
module uart_dbtx
    import udt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit9_en,
    input  logic              bit9_val,
    output logic              hold_empty,
    output logic              shift_empty,
    output logic              collide_o,
    output logic              tx_o
);

    tx_word_t wr_word;
    tx_word_t hold_word;
    logic     hold_full;
    logic     take;
    logic     restart;
    logic     run;
    logic     tick;
    logic     idle;

    assign wr_word = '{nine_en: bit9_en, nine: bit9_val, data: wr_data};

    udt_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .div     (baud_div),
        .tick    (tick)
    );

    udt_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_word (wr_word),
        .take    (take),
        .full    (hold_full),
        .word    (hold_word),
        .collide (collide_o)
    );

    udt_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .hold_full (hold_full),
        .hold_word (hold_word),
        .take      (take),
        .restart   (restart),
        .run       (run),
        .idle      (idle),
        .tx        (tx_o)
    );

    assign hold_empty  = !hold_full;
    assign shift_empty = idle;

endmodule

// File: rtl/udt_checker.sv
module udt_checker (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic hold_empty,
    input logic shift_empty,
    input logic tx_o,
    input logic collide_o
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        shift_empty |-> tx_o); // R1

    AST_STOP_BEFORE_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(shift_empty) |-> $past(tx_o)); // R2

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && hold_empty) |=> !hold_empty); // R4

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (shift_empty && !hold_empty) |=> (!shift_empty && !tx_o)); // R4

    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (rst)
        (hold_empty && !wr_stb) |=> hold_empty); // R6

    AST_COLLIDE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        collide_o |-> ($past(wr_stb) && !$past(hold_empty))); // R8

    AST_COLLIDE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (collide_o && !$past(wr_stb && !hold_empty, 1)) |-> 1'b0); // R8

endmodule

bind uart_dbtx udt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_stb),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty),
    .tx_o        (tx_o),
    .collide_o   (collide_o)
);

// File: tb/sim_uart_dbtx.sv
`timescale 1ns/1ps
module sim_uart_dbtx;

    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] baud_div = 16'd5;
    logic             wr_stb = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             bit9_en = 1'b0;
    logic             bit9_val = 1'b0;
    logic             hold_empty, shift_empty, collide_o, tx_o;

    always #2.5 clk = ~clk;

    uart_dbtx #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst), .baud_div(baud_div), .wr_stb(wr_stb),
        .wr_data(wr_data), .bit9_en(bit9_en), .bit9_val(bit9_val),
        .hold_empty(hold_empty), .shift_empty(shift_empty),
        .collide_o(collide_o), .tx_o(tx_o)
    );

    typedef struct {
        logic [7:0] d;
        logic       ne;
        logic       n;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   D = 6;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // driver: called at a negedge, returns at the negedge after the sampling edge
    task automatic put(logic [7:0] d, logic ne, logic n, bit accepted);
        exp_t e;
        wr_stb   = 1'b1;
        wr_data  = d;
        bit9_en  = ne;
        bit9_val = n;
        if (accepted) begin
            e.d = d; e.ne = ne; e.n = n;
            q.push_back(e);
        end
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_idle();
        while (!(shift_empty && hold_empty)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: decode frames from the line and compare with the queue
    initial begin
        logic prev;
        prev = 1'b1;
        wait (!rst);
        forever begin
            @(negedge clk);
            if (prev && !tx_o) begin
                exp_t       e;
                bit         have;
                bit         start_ok;
                int         nb;
                int         dl;
                logic [8:0] got;
                logic       stop_ok;
                dl       = D;
                have     = (q.size() > 0);
                start_ok = 1'b1;
                stop_ok  = 1'b1;
                got      = '0;
                if (have) e = q.pop_front();
                else begin
                    e.d = '0; e.ne = 1'b0; e.n = 1'b0;
                end
                check(have, "R10", "frame with no queued write", 1, 0);
                nb = e.ne ? 9 : 8;
                for (int j = 1; j < dl; j++) begin
                    @(negedge clk);
                    if (tx_o) start_ok = 1'b0;
                end
                check(start_ok, "R2", "start bit low for full width", int'(start_ok), 1);
                repeat (dl / 2 + 1) @(negedge clk);
                got[0] = tx_o;
                for (int b = 1; b < nb; b++) begin
                    repeat (dl) @(negedge clk);
                    got[b] = tx_o;
                end
                repeat (dl) @(negedge clk);
                if (!tx_o) stop_ok = 1'b0;
                for (int j = 0; j < dl - 1 - dl / 2; j++) begin
                    @(negedge clk);
                    if (!tx_o) stop_ok = 1'b0;
                end
                check(stop_ok, "R2", "stop bit high", int'(stop_ok), 1);
                if (e.ne)
                    check(got == {e.n, e.d}, "R3", "nine-bit frame", int'(got), int'({e.n, e.d}));
                else
                    check(got[7:0] == e.d, "R2", "eight-bit frame", int'(got[7:0]), int'(e.d));
            end
            prev = tx_o;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(tx_o == 1'b1, "R1", "tx after reset", int'(tx_o), 1);
        check(hold_empty == 1'b1, "R1", "hold_empty after reset", int'(hold_empty), 1);
        check(shift_empty == 1'b1, "R1", "shift_empty after reset", int'(shift_empty), 1);
        check(collide_o == 1'b0, "R1", "collide after reset", int'(collide_o), 0);

        // R4 start from idle
        put(8'hA5, 1'b0, 1'b0, 1'b1);
        check(hold_empty == 1'b0, "R4", "hold_empty after write", int'(hold_empty), 0);
        check(shift_empty == 1'b1, "R4", "shift_empty before load", int'(shift_empty), 1);
        @(negedge clk);
        check(hold_empty == 1'b1, "R4", "hold_empty after load", int'(hold_empty), 1);
        check(shift_empty == 1'b0, "R4", "shift_empty after load", int'(shift_empty), 0);
        check(tx_o == 1'b0, "R4", "start bit begins", int'(tx_o), 0);
        wait_idle();

        // R5, R6, R7 back-to-back with transfer at stop start
        put(8'h3C, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        put(8'hC1, 1'b0, 1'b0, 1'b1);
        repeat (9 * D - 2) @(negedge clk);
        check(hold_empty == 1'b0, "R6", "hold full in last data bit", int'(hold_empty), 0);
        @(negedge clk);
        check(hold_empty == 1'b1, "R6", "hold empty at stop start", int'(hold_empty), 1);
        check(shift_empty == 1'b0, "R7", "busy during stop", int'(shift_empty), 0);
        repeat (D) @(negedge clk);
        check(tx_o == 1'b0, "R5", "next start right after stop", int'(tx_o), 0);
        check(shift_empty == 1'b0, "R7", "busy between frames", int'(shift_empty), 0);
        wait_idle();
        check(shift_empty == 1'b1, "R7", "idle after frames", int'(shift_empty), 1);

        // R8 collision at idle and in flight
        put(8'h11, 1'b0, 1'b0, 1'b1);
        put(8'h22, 1'b0, 1'b0, 1'b0);
        check(collide_o == 1'b1, "R8", "collision pulse", int'(collide_o), 1);
        @(negedge clk);
        check(collide_o == 1'b0, "R8", "collision pulse ends", int'(collide_o), 0);
        wait_idle();
        put(8'h4E, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        put(8'hB7, 1'b0, 1'b0, 1'b1);
        put(8'hFF, 1'b0, 1'b0, 1'b0);
        check(collide_o == 1'b1, "R8", "collision in flight", int'(collide_o), 1);
        wait_idle();

        // R3 nine-bit frames, mixed back-to-back
        put(8'h5A, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        put(8'hC3, 1'b1, 1'b0, 1'b1);
        put(8'h0F, 1'b0, 1'b0, 1'b0);
        wait_idle();
        put(8'h0F, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        put(8'h81, 1'b1, 1'b1, 1'b1);
        wait_idle();

        // R9 mode inputs toggled during a frame
        put(8'h96, 1'b0, 1'b0, 1'b1);
        repeat (D * 3) begin
            @(negedge clk);
            bit9_en  = ~bit9_en;
            bit9_val = ~bit9_val;
        end
        bit9_en  = 1'b1;
        bit9_val = 1'b1;
        wait_idle();
        bit9_en  = 1'b0;
        bit9_val = 1'b0;
        check(q.size() == 0, "R9", "frames pending after toggle test", q.size(), 0);

        // R10 write around the stop-end tick
        for (int k = -2; k <= 1; k++) begin
            put(8'h40, 1'b0, 1'b0, 1'b1);
            repeat (10 * D + k) @(negedge clk);
            put(8'h80 | 8'(k + 2), 1'b0, 1'b0, 1'b1);
            wait_idle();
            check(q.size() == 0, "R10", "missing frame after boundary write", q.size(), 0);
            repeat (D * 12) @(negedge clk);
            check(shift_empty == 1'b1, "R10", "no extra frame", int'(shift_empty), 1);
        end

        // R2 different divisor
        baud_div = 16'd2;
        D        = 3;
        put(8'h6D, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        put(8'h92, 1'b0, 1'b0, 1'b1);
        wait_idle();

        check(q.size() == 0, "R10", "all expected frames seen", q.size(), 0);
        finish_run();
    end

endmodule